// File: doc/BRIEF.md
# Sampling and Queuing Message Port

This block is the receive-side buffer of one message port. Messages arrive as streams of data words. The first word carries a start marker and the final word carries an end marker. A reader asks for a message with a one-cycle request, and the block returns the whole message as a burst of words that ends with a last flag.

The port runs in one of two modes, chosen by a static input.

- **Sampling mode:** the port keeps only the newest complete message. A new message replaces it. Reading leaves it in place, so it can be read again and again.
- **Queuing mode:** the port keeps up to a fixed number of messages in arrival order. Each read hands out the oldest message and removes it.

Status outputs show whether a message is stored, whether the queue is full, whether a message was lost to a full queue, and whether the latest write is recent. The recent-write flag lets a consumer tell a sender that has stopped from one that keeps sending the same content.

Storage is one shared array of slots, and each slot records its own message length. A message becomes visible only when its end word is accepted. A read that has already started always delivers one complete, consistent message.

Top module: `msg_port`

## Requirements
- R1: After reset, `empty` is high, and `full`, `fresh`, `overflow` and `rd_valid` are all low.
- R2: In sampling mode (`queue_mode`=0), each completed message replaces the stored one, and a read returns the newest completed message.
- R3: In sampling mode, a read does not remove the message. Repeated reads return the same words, and `empty` stays low.
- R4: `fresh` rises in the cycle after a message's end word is accepted. It stays high for FRESH_LIMIT cycles while no other message completes, then drops until the next completion. Reads do not affect it.
- R5: In queuing mode (`queue_mode`=1), messages are read in arrival order, each read removes exactly one message, and `empty` rises once the last stored message has been read.
- R6: In queuing mode, `full` is high while DEPTH messages are stored. A message whose start word arrives while the queue is full is dropped whole and sets `overflow`. `overflow` stays high until an `ovf_clr` pulse. If a new drop coincides with `ovf_clr`, `overflow` stays high.
- R7: A partly written message is never visible to a reader. A sampling read that is already under way returns the complete previous message, even while a new one is being written.
- R8: Each stored message keeps its own length, from 1 to MAX_WORDS. Words past MAX_WORDS are discarded, and the read burst is MAX_WORDS long.
- R9: A read request is honoured only when the port is not empty and no burst is running.
  - The first word appears in the cycle after the request edge.
  - Words follow on consecutive cycles, and `rd_last` marks the final word.
  - A request while empty, or while a burst is running, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| queue_mode | input | 1 | 0 = sampling, 1 = queuing; change only during reset |
| wr_valid | input | 1 | Write word valid this cycle |
| wr_sop | input | 1 | Word is the first of a message |
| wr_eop | input | 1 | Word is the last of a message |
| wr_data | input | DATA_W | Write word |
| ovf_clr | input | 1 | Pulse to clear the overflow flag |
| rd_req | input | 1 | Request one whole message |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| rd_last | output | 1 | Final word of the read burst |
| empty | output | 1 | No message available |
| full | output | 1 | Queue holds DEPTH messages (queuing mode only) |
| fresh | output | 1 | A message completed within the last FRESH_LIMIT cycles |
| overflow | output | 1 | Sticky: a message was dropped on a full queue |

## Verification
Each read word is due one cycle after the previous one, and the first word one cycle after the request edge. The status flags change in the cycle after the edge that accepts the end word or the start word they react to. `fresh` falls exactly FRESH_LIMIT cycles after the completing edge.

Stimulus is applied on falling edges. A scoreboard queue is loaded with the expected words before each request, and a monitor compares every `rd_valid` cycle on the falling edge against the head of that queue. The result is therefore independent of how many cycles a burst takes. Flag checks are made on the falling edge that follows the accepting rising edge, and the freshness window is counted cycle by cycle from the end of a write.

// File: rtl/msg_port_pkg.sv
// Package: shared types for the message port.
package msg_port_pkg;
    // Operating mode of the port, taken from the queue_mode input.
    typedef enum logic {
        MODE_SAMPLING = 1'b0,
        MODE_QUEUING  = 1'b1
    } port_mode_e;
endpackage

// File: rtl/msg_port_wr.sv
// Write assembler: follows word streams framed by start and end markers,
// produces per-word storage writes and a commit pulse with the message length.
// Assumes: a start word always begins a new message (an unfinished one is
// abandoned); words outside a message without a start marker are ignored;
// MAX_WORDS >= 2.
module msg_port_wr #(
    parameter int MAX_WORDS = 8,
    parameter int LEN_W     = $clog2(MAX_WORDS + 1),
    parameter int IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic             drop_new,
    output logic             msg_start,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output logic             commit,
    output logic [LEN_W-1:0] commit_len,
    output logic             overflow_evt
);
    logic             in_msg;
    logic             dropping;
    logic [LEN_W-1:0] wcnt;
    logic             active;
    logic             drop_cur;
    logic             fits;
    logic [LEN_W-1:0] idx_ext;
    logic [LEN_W-1:0] new_cnt;

    // Decode the current word: position, whether it is kept, and whether it commits.
    always_comb begin
        msg_start    = wr_valid && wr_sop;
        active       = msg_start || (wr_valid && in_msg);
        drop_cur     = msg_start ? drop_new : dropping;
        idx_ext      = msg_start ? '0 : wcnt;
        fits         = idx_ext < LEN_W'(MAX_WORDS);
        mem_we       = active && !drop_cur && fits;
        mem_idx      = idx_ext[IDX_W-1:0];
        new_cnt      = (active && fits) ? idx_ext + LEN_W'(1) : wcnt;
        commit       = active && wr_eop && !drop_cur;
        commit_len   = new_cnt;
        overflow_evt = msg_start && drop_new;
    end

    // Track message framing, drop state and stored word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_msg   <= 1'b0;
            dropping <= 1'b0;
            wcnt     <= '0;
        end else if (active) begin
            in_msg   <= !wr_eop;
            dropping <= drop_cur;
            wcnt     <= new_cnt;
        end
    end
endmodule

// File: rtl/msg_port_rd.sv
// Read sequencer: on an accepted request it latches a slot and steps a word
// pointer once per cycle until the slot's stored length is reached.
// Assumes: the length of the latched slot does not change during the burst.
module msg_port_rd #(
    parameter int SLOT_W = 2,
    parameter int LEN_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              avail,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic [LEN_W-1:0]  cur_len,
    output logic              busy,
    output logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  ptr,
    output logic              last
);
    logic start;

    // Accept a request only when idle with a message present; flag the final word.
    always_comb begin
        start = rd_req && !busy && avail;
        last  = busy && ((LEN_W'(ptr) + LEN_W'(1)) == cur_len);
    end

    // Run the burst: latch the slot, advance the pointer, stop after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            slot <= '0;
            ptr  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            slot <= start_slot;
            ptr  <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                ptr <= ptr + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/msg_port_fresh.sv
// Freshness timer: an age counter cleared by each completed write, saturating
// at FRESH_LIMIT; fresh is high while the age is below the limit.
// Assumes: FRESH_LIMIT >= 1. Reset starts the counter saturated (not fresh).
module msg_port_fresh #(
    parameter int FRESH_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic fresh
);
    localparam int AGE_W = $clog2(FRESH_LIMIT + 1);

    logic [AGE_W-1:0] age;

    // Count cycles since the last completed message, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= AGE_W'(FRESH_LIMIT);
        end else if (restart) begin
            age <= '0;
        end else if (age < AGE_W'(FRESH_LIMIT)) begin
            age <= age + AGE_W'(1);
        end
    end

    assign fresh = age < AGE_W'(FRESH_LIMIT);
endmodule

// File: rtl/msg_port.sv
// Message port top: one array of DEPTH message slots of MAX_WORDS words each.
// Queuing mode uses the slots as a circular message FIFO. Sampling mode keeps
// one current slot and writes each new message into a slot that is neither
// current nor being read, then switches to it on commit.
// Assumes: queue_mode changes only while reset is asserted; DEPTH >= 3;
// MAX_WORDS >= 2.
module msg_port #(
    parameter int DATA_W      = 16,
    parameter int MAX_WORDS   = 8,
    parameter int DEPTH       = 4,
    parameter int FRESH_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              queue_mode,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovf_clr,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              empty,
    output logic              full,
    output logic              fresh,
    output logic              overflow
);
    import msg_port_pkg::*;

    localparam int SLOT_W = $clog2(DEPTH);
    localparam int LEN_W  = $clog2(MAX_WORDS + 1);
    localparam int IDX_W  = $clog2(MAX_WORDS);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int WORDS  = DEPTH * MAX_WORDS;
    localparam int ADDR_W = $clog2(WORDS);

    port_mode_e mode;
    assign mode = port_mode_e'(queue_mode);

    logic [DATA_W-1:0] mem     [WORDS];
    logic [LEN_W-1:0]  len_mem [DEPTH];

    logic [SLOT_W-1:0] head, tail, cur, wslot_q, pick, slot_now, rd_start_slot;
    logic [CNT_W-1:0]  count;
    logic              have_msg;

    logic              msg_start, mem_we, commit, overflow_evt, drop_new, pop;
    logic [IDX_W-1:0]  mem_idx;
    logic [LEN_W-1:0]  commit_len;
    logic              rd_busy, rd_done;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_ptr;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    msg_port_wr #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .drop_new(drop_new),
        .msg_start(msg_start), .mem_we(mem_we), .mem_idx(mem_idx),
        .commit(commit), .commit_len(commit_len), .overflow_evt(overflow_evt)
    );

    msg_port_rd #(.SLOT_W(SLOT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .avail(!empty),
        .start_slot(rd_start_slot), .cur_len(len_mem[rd_slot]),
        .busy(rd_busy), .slot(rd_slot), .ptr(rd_ptr), .last(rd_done)
    );

    msg_port_fresh #(.FRESH_LIMIT(FRESH_LIMIT)) u_fresh (
        .clk(clk), .rst_n(rst_n), .restart(commit), .fresh(fresh)
    );

    // Sampling mode: lowest slot that is neither current nor under read.
    always_comb begin
        pick = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (SLOT_W'(i) != cur && !(rd_busy && SLOT_W'(i) == rd_slot)) begin
                pick = SLOT_W'(i);
            end
        end
    end

    // Slot selection, drop decision, addresses and status flags.
    always_comb begin
        drop_new      = (mode == MODE_QUEUING) && (count == CNT_W'(DEPTH));
        slot_now      = msg_start ? ((mode == MODE_QUEUING) ? tail : pick) : wslot_q;
        rd_start_slot = (mode == MODE_QUEUING) ? head : cur;
        pop           = rd_done && (mode == MODE_QUEUING);
        wr_addr       = ADDR_W'(slot_now) * ADDR_W'(MAX_WORDS) + ADDR_W'(mem_idx);
        rd_addr       = ADDR_W'(rd_slot) * ADDR_W'(MAX_WORDS) + ADDR_W'(rd_ptr);
        empty         = (mode == MODE_QUEUING) ? (count == '0) : !have_msg;
        full          = (mode == MODE_QUEUING) && (count == CNT_W'(DEPTH));
    end

    // Word and length storage (no reset: only committed entries are read).
    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[wr_addr] <= wr_data;
        end
        if (commit) begin
            len_mem[slot_now] <= commit_len;
        end
    end

    // Hold the target slot of the message being written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wslot_q <= '0;
        end else if (msg_start) begin
            wslot_q <= slot_now;
        end
    end

    // Queue bookkeeping: tail on commit, head on completed read, occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (mode == MODE_QUEUING) begin
            if (commit) begin
                tail <= (tail == SLOT_W'(DEPTH - 1)) ? '0 : tail + SLOT_W'(1);
            end
            if (pop) begin
                head <= (head == SLOT_W'(DEPTH - 1)) ? '0 : head + SLOT_W'(1);
            end
            if (commit && !pop) begin
                count <= count + CNT_W'(1);
            end else if (pop && !commit) begin
                count <= count - CNT_W'(1);
            end
        end
    end

    // Sampling bookkeeping: switch the current slot on each completed message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            have_msg <= 1'b0;
        end else if (mode == MODE_SAMPLING && commit) begin
            cur      <= slot_now;
            have_msg <= 1'b1;
        end
    end

    // Sticky overflow: a new drop wins over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (overflow_evt) begin
            overflow <= 1'b1;
        end else if (ovf_clr) begin
            overflow <= 1'b0;
        end
    end

    assign rd_valid = rd_busy;
    assign rd_last  = rd_done;
    assign rd_data  = mem[rd_addr];
endmodule

// File: rtl/msg_port_chk.sv
// Checker for msg_port: port-level temporal properties, bound to every instance.
// Assumes: the same reset as the port; properties are off while reset is low.
module msg_port_chk (
    input logic clk,
    input logic rst_n,
    input logic queue_mode,
    input logic ovf_clr,
    input logic rd_valid,
    input logic rd_last,
    input logic empty,
    input logic full,
    input logic overflow
);
    // R3: a sampling port never loses its message once it has one.
    assert_sample_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_mode && !empty) |=> !empty);

    // R6: full means messages are present.
    assert_full_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !empty);

    // R6: full only exists in queuing mode.
    assert_full_queue_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> queue_mode);

    // R6: overflow stays set until a clear pulse.
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    // R9: a burst runs without gaps until its final word.
    assert_burst_gapless_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> rd_valid);

    // R9: a burst only runs while a message is held.
    assert_read_needs_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !empty);

    // R9: rd_last only marks a valid word.
    assert_last_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
endmodule

bind msg_port msg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode), .ovf_clr(ovf_clr),
    .rd_valid(rd_valid), .rd_last(rd_last), .empty(empty), .full(full),
    .overflow(overflow)
);

// File: tb/msg_port_test.sv
// Scoreboard bench for msg_port: driver tasks load expected words, and a
// falling-edge monitor compares every read word against them.
module msg_port_test;
    localparam int CLK_PERIOD  = 10;
    localparam int DATA_W      = 16;
    localparam int MAX_WORDS   = 8;
    localparam int DEPTH       = 4;
    localparam int FRESH_LIMIT = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              queue_mode = 1'b0;
    logic              wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ovf_clr = 1'b0, rd_req = 1'b0;
    logic              rd_valid, rd_last, empty, full, fresh, overflow;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R1";

    logic [DATA_W-1:0] sb_data[$];
    logic              sb_last[$];

    msg_port #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .DEPTH(DEPTH),
               .FRESH_LIMIT(FRESH_LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .empty(empty), .full(full), .fresh(fresh), .overflow(overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compare every read word with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (sb_data.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected word actual %0h expected none", cur_tag, rd_data);
            end else begin
                logic [DATA_W-1:0] d;
                logic              l;
                d = sb_data.pop_front();
                l = sb_last.pop_front();
                if (rd_data !== d || rd_last !== l) begin
                    errors++;
                    $display("FAIL %s actual %0h/%0b expected %0h/%0b",
                             cur_tag, rd_data, rd_last, d, l);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        summary();
    end

    task automatic word(input int d, input bit s, input bit e);
        wr_valid = 1'b1;
        wr_sop   = s;
        wr_eop   = e;
        wr_data  = DATA_W'(d);
        @(negedge clk);
        wr_valid = 1'b0;
        wr_sop   = 1'b0;
        wr_eop   = 1'b0;
    endtask

    task automatic send(input int base, input int n);
        for (int i = 0; i < n; i++) word(base + i, i == 0, i == n - 1);
    endtask

    task automatic expect_msg(input int base, input int n);
        int m;
        m = (n > MAX_WORDS) ? MAX_WORDS : n;
        for (int i = 0; i < m; i++) begin
            sb_data.push_back(DATA_W'(base + i));
            sb_last.push_back(i == m - 1);
        end
    endtask

    task automatic read_msg();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        while (rd_valid) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        chk(sb_data.size() == 0, tag, sb_data.size(), 0);
    endtask

    task automatic do_reset(input bit qm);
        rst_n = 1'b0;
        queue_mode = qm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0);
        // R1: reset state
        cur_tag = "R1";
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(fresh == 1'b0, "R1 fresh", fresh, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);

        // R9: request while empty is ignored
        cur_tag = "R9";
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R9 empty request", rd_valid, 0);

        // R2, R4: sampling write, then read
        send(32'h100, 3);
        chk(fresh == 1'b1, "R4 fresh after write", fresh, 1);
        chk(empty == 1'b0, "R2 empty after write", empty, 0);
        cur_tag = "R2";
        expect_msg(32'h100, 3);
        read_msg();
        drained("R2 first read");

        // R3: repeated read returns the same message
        cur_tag = "R3";
        expect_msg(32'h100, 3);
        read_msg();
        drained("R3 second read");
        chk(empty == 1'b0, "R3 still held", empty, 0);

        // R2: replacement by a newer message
        send(32'h200, 5);
        cur_tag = "R2";
        expect_msg(32'h200, 5);
        read_msg();
        drained("R2 replaced");

        // R7: a partial message is invisible
        word(32'h400, 1'b1, 1'b0);
        word(32'h401, 1'b0, 1'b0);
        cur_tag = "R7";
        expect_msg(32'h200, 5);
        read_msg();
        drained("R7 partial hidden");
        word(32'h402, 1'b0, 1'b1);
        expect_msg(32'h400, 3);
        read_msg();
        drained("R7 completed visible");

        // R7: a read under way is unaffected by a concurrent write
        expect_msg(32'h400, 3);
        fork
            read_msg();
            send(32'h500, 4);
        join
        drained("R7 read during write");
        expect_msg(32'h500, 4);
        read_msg();
        drained("R7 new after write");

        // R8 and R4: oversized message, then the freshness window
        send(32'h300, 11);
        chk(fresh == 1'b1, "R4 fresh at age 0", fresh, 1);
        repeat (FRESH_LIMIT - 1) @(negedge clk);
        chk(fresh == 1'b1, "R4 fresh at limit-1", fresh, 1);
        @(negedge clk);
        chk(fresh == 1'b0, "R4 stale at limit", fresh, 0);
        cur_tag = "R8";
        expect_msg(32'h300, 11);
        read_msg();
        drained("R8 truncated");
        chk(fresh == 1'b0, "R4 read leaves stale", fresh, 0);

        // R5: queuing mode order, single-word message included
        do_reset(1'b1);
        chk(empty == 1'b1, "R1 queue reset empty", empty, 1);
        send(32'h600, 1);
        send(32'h610, 2);
        send(32'h620, 4);
        chk(full == 1'b0, "R6 not full at 3", full, 0);
        cur_tag = "R5";
        expect_msg(32'h600, 1);
        read_msg();
        expect_msg(32'h610, 2);
        read_msg();
        expect_msg(32'h620, 4);
        read_msg();
        drained("R5 fifo order");
        chk(empty == 1'b1, "R5 empty after all", empty, 1);

        // R9: a request during a burst is ignored
        send(32'h700, 4);
        send(32'h710, 2);
        cur_tag = "R9";
        expect_msg(32'h700, 4);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        while (rd_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        drained("R9 busy request");
        chk(rd_valid == 1'b0, "R9 no second burst", rd_valid, 0);
        chk(empty == 1'b0, "R9 second message kept", empty, 0);
        cur_tag = "R5";
        expect_msg(32'h710, 2);
        read_msg();
        drained("R5 remaining message");

        // R6: full, drop on overflow, sticky flag, clear and set-wins
        send(32'h800, 2);
        send(32'h810, 2);
        send(32'h820, 2);
        send(32'h830, 2);
        chk(full == 1'b1, "R6 full at depth", full, 1);
        send(32'h840, 2);
        chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
        chk(full == 1'b1, "R6 still full", full, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(overflow == 1'b0, "R6 clear pulse", overflow, 0);
        ovf_clr = 1'b1;
        word(32'h850, 1'b1, 1'b0);
        ovf_clr = 1'b0;
        word(32'h851, 1'b0, 1'b1);
        chk(overflow == 1'b1, "R6 set wins over clear", overflow, 1);
        cur_tag = "R6";
        expect_msg(32'h800, 2);
        expect_msg(32'h810, 2);
        expect_msg(32'h820, 2);
        expect_msg(32'h830, 2);
        for (int i = 0; i < DEPTH; i++) read_msg();
        drained("R6 dropped messages absent");
        chk(empty == 1'b1, "R6 empty after drain", empty, 1);
        chk(overflow == 1'b1, "R6 sticky after reads", overflow, 1);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule